// File: doc/BRIEF.md
# Per-Line Cache Leakage Sequence Detector

This block sits beside a direct-mapped cache and watches every processor request. It uses the request address to tell which of two security domains made the access: a victim address window or an attacker address window, both set by parameters. It uses the cache hit flag to tell whether the access hit or missed. For each cache line it keeps a 3-bit sequence state in a register file. On every tracked request it reads the state of the addressed line, computes the next state from the actor and the hit/miss outcome, and writes that state back. Lines that the request does not address keep their state.

A line that completes a three-step leakage sequence reaches the Attack state, and the block counts one trigger. Triggers accumulate in a saturating counter. The interrupt rises once the count reaches a threshold, which filters out the occasional false match that benign code produces. Software acknowledges the interrupt by pulsing a clear input, and that pulse also zeroes the counter.

Top module: `line_leak_detector`

## Requirements
- R1: After a synchronous reset `trig_count` is 0, `irq` is 0, and every line state is Start, so the first tracked access on any line is a first step.
- R2: The line index is address bits [9:4], and bits [3:0] are the byte offset. An access changes only the state of the line it indexes.
- R3: The actor is decided by address. An address in [0x0001_0000, 0x0001_FFFF] is a victim access. An address in [0x0002_0000, 0x0002_FFFF] is an attacker access. Any other address leaves every line state and the counter unchanged.
- R4: The sequence victim access (hit or miss), then attacker miss, then victim miss on one line increments `trig_count` by one on the clock edge of the third access.
- R5: Transitions. Start goes to V or A by actor. From V, a victim access goes to VV, an attacker miss goes to VA, and an attacker hit restarts. From A, an attacker access goes to AA, a victim miss goes to AV, and a victim hit restarts. From VV, VA, AV or AA, a miss by either actor goes to Attack and counts a trigger, while a hit restarts. A restart sets the line to V for a victim or A for an attacker.
- R6: After Attack, the next tracked access on that line restarts at V or A, so two further accesses cannot produce a new trigger.
- R7: `trig_count` saturates at 127 and never wraps.
- R8: `irq` is 1 in the cycle after the edge at which `trig_count` reaches THRESHOLD (default 100). It stays 1 until a clear pulse.
- R9: A cycle with `irq_clear` high sets `trig_count` to 0 and `irq` to 0 at that edge. The clear takes priority over a trigger in the same cycle.
- R10: A cycle with `req` low changes no line state and does not change the counter, whatever the address and hit flag are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Processor request strobe |
| addr | input | 32 | Request address |
| hit | input | 1 | Cache hit flag for the request |
| irq_clear | input | 1 | Pulse to acknowledge the interrupt and zero the counter |
| trig_count | output | 7 | Saturating count of completed leakage sequences |
| irq | output | 1 | Interrupt, high once the count has reached the threshold |

## Verification
The assertions assume that `hit` is only meaningful while `req` is high. They also assume that the victim and attacker windows do not overlap, so each tracked address has a single actor. The stimulus keeps to both assumptions: it drives hit values only with a request, and it draws victim, attacker and outside addresses from three disjoint windows. The sweep applies every ordered triple of the five access kinds to each of the 64 lines. It varies the upper address bits and the byte offset, so that only the index bits select the line.

// File: rtl/line_leak_detector.sv
`timescale 1ns/1ps
module line_leak_detector #(
  parameter int ADDR_W    = 32,
  parameter int OFFSET_W  = 4,
  parameter int INDEX_W   = 6,
  parameter int CNT_W     = 7,
  parameter int THRESHOLD = 100,
  parameter logic [ADDR_W-1:0] VICT_LO = 32'h0001_0000,
  parameter logic [ADDR_W-1:0] VICT_HI = 32'h0001_FFFF,
  parameter logic [ADDR_W-1:0] ATK_LO  = 32'h0002_0000,
  parameter logic [ADDR_W-1:0] ATK_HI  = 32'h0002_FFFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  input  logic              hit,
  input  logic              irq_clear,
  output logic [CNT_W-1:0]  trig_count,
  output logic              irq
);
  localparam int LINES = 1 << INDEX_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] THR = CNT_W'(THRESHOLD);

  typedef enum logic [2:0] {
    S_START, S_V, S_A, S_VV, S_VA, S_AV, S_AA, S_ATK
  } lstate_t;

  lstate_t st_mem [LINES];
  lstate_t cur, nxt, restart;

  logic [INDEX_W-1:0] idx;
  logic in_v, in_a, is_v, is_a, track, ev_miss, fire;
  logic [CNT_W-1:0] cnt_nx;

  assign idx     = addr[OFFSET_W +: INDEX_W];
  assign in_v    = (addr >= VICT_LO) && (addr <= VICT_HI);
  assign in_a    = (addr >= ATK_LO) && (addr <= ATK_HI);
  assign is_v    = req & in_v;
  assign is_a    = req & ~in_v & in_a;
  assign track   = is_v | is_a;
  assign ev_miss = req & ~hit;
  assign cur     = st_mem[idx];
  assign restart = is_v ? S_V : S_A;

  always_comb begin
    unique case (cur)
      S_START, S_ATK: nxt = restart;
      S_V:            nxt = is_v ? S_VV : (ev_miss ? S_VA : S_A);
      S_A:            nxt = is_a ? S_AA : (ev_miss ? S_AV : S_V);
      default:        nxt = ev_miss ? S_ATK : restart;
    endcase
  end

  assign fire = track && (nxt == S_ATK);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LINES; i++) st_mem[i] <= S_START;
    end else if (track) begin
      st_mem[idx] <= nxt;
    end
  end

  always_comb begin
    if (irq_clear)                         cnt_nx = '0;
    else if (fire && trig_count != CNT_MAX) cnt_nx = trig_count + 1'b1;
    else                                   cnt_nx = trig_count;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_count <= '0;
      irq        <= 1'b0;
    end else begin
      trig_count <= cnt_nx;
      irq        <= (cnt_nx >= THR);
    end
  end

  // R7: never wraps (monotonic unless cleared)
  a_r7_no_wrap: assert property (@(posedge clk) disable iff (rst)
    !irq_clear |=> trig_count >= $past(trig_count));

  // R4: at most one trigger per request
  a_r4_single_step: assert property (@(posedge clk) disable iff (rst)
    (!irq_clear && trig_count != CNT_MAX) |=> trig_count <= $past(trig_count) + 1'b1);

  // R9: clear empties counter and drops interrupt
  a_r9_clear: assert property (@(posedge clk) disable iff (rst)
    irq_clear |=> (trig_count == '0) && !irq);

  // R8: interrupt holds until cleared
  a_r8_irq_hold: assert property (@(posedge clk) disable iff (rst)
    (irq && !irq_clear) |=> irq);

  // R10: idle cycles leave the counter alone
  a_r10_idle: assert property (@(posedge clk) disable iff (rst)
    (!req && !irq_clear) |=> $stable(trig_count));

  // R3: addresses outside both windows do not count
  a_r3_outside: assert property (@(posedge clk) disable iff (rst)
    (req && !in_v && !in_a && !irq_clear) |=> $stable(trig_count));
endmodule

// File: tb/tb_line_leak_detector.sv
`timescale 1ns/1ps
module tb_line_leak_detector;
  logic clk = 0, rst = 1, req = 0, hit = 0, irq_clear = 0;
  logic [31:0] addr = '0;
  logic [6:0] trig_count;
  logic irq;
  int total = 0, bad = 0;
  int m [64];
  int mc = 0;

  line_leak_detector dut (.clk(clk), .rst(rst), .req(req), .addr(addr), .hit(hit),
    .irq_clear(irq_clear), .trig_count(trig_count), .irq(irq));

  always #2.5 clk = ~clk;

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // e: 0 victim hit, 1 victim miss, 2 attacker hit, 3 attacker miss, 4 outside
  function automatic int mnext(int s, int e);
    bit v = (e < 2);
    bit miss = (e % 2 == 1);
    int rs = v ? 1 : 2;
    case (s)
      0, 7: return rs;
      1: return v ? 3 : (miss ? 4 : 2);
      2: return !v ? 6 : (miss ? 5 : 1);
      default: return miss ? 7 : rs;
    endcase
  endfunction

  task automatic acc(string tag, int line, int e, int tag_bits, bit clr);
    int ns;
    @(negedge clk);
    req = 1;
    irq_clear = clr;
    case (e)
      0, 1: addr = 32'h0001_0000;
      2, 3: addr = 32'h0002_0000;
      default: addr = (tag_bits % 2) ? 32'h0003_0000 : 32'h0000_8000;
    endcase
    addr = addr | ((tag_bits % 32) << 10) | (line << 4) | (tag_bits % 16);
    hit = (e == 4) ? tag_bits[1] : (e % 2 == 0);
    if (e != 4) begin
      ns = mnext(m[line], e);
      m[line] = ns;
      if (ns == 7 && mc < 127) mc++;
    end
    if (clr) mc = 0;
    @(negedge clk);
    req = 0;
    irq_clear = 0;
    check(tag, trig_count, mc);
    check(tag, irq, (mc >= 100));
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    @(negedge clk); @(negedge clk); rst = 0;
    for (int i = 0; i < 64; i++) m[i] = 0;
    mc = 0;
  endtask

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    check("R1", trig_count, 0);
    check("R1", irq, 0);
    // R4: victim any, attacker miss, victim miss
    acc("R4", 5, 0, 3, 0); acc("R4", 5, 3, 7, 0); acc("R4", 5, 1, 9, 0);
    check("R4", trig_count, 1);
    // R2: split across lines gives nothing; interleaved per-line both fire
    acc("R2", 1, 0, 1, 0); acc("R2", 2, 3, 2, 0); acc("R2", 1, 1, 3, 0);
    acc("R2", 3, 0, 4, 0); acc("R2", 4, 2, 5, 0); acc("R2", 3, 3, 6, 0);
    acc("R2", 4, 1, 7, 0); acc("R2", 3, 1, 8, 0); acc("R2", 4, 3, 9, 0);
    check("R2", trig_count, 3);
    // R3: outside accesses do not disturb a pending sequence
    acc("R3", 6, 0, 1, 0); acc("R3", 6, 4, 2, 0); acc("R3", 6, 4, 3, 0);
    acc("R3", 6, 3, 4, 0); acc("R3", 6, 1, 5, 0);
    check("R3", trig_count, 4);
    // R10: idle cycle with a miss address does not advance line 7
    acc("R10", 7, 0, 1, 0); acc("R10", 7, 3, 2, 0);
    @(negedge clk); addr = 32'h0001_0070; hit = 0;
    @(negedge clk);
    check("R10", trig_count, 4);
    acc("R10", 7, 1, 3, 0);
    check("R10", trig_count, 5);
    // R6: after Attack, two accesses do not trigger
    acc("R6", 7, 3, 4, 0); acc("R6", 7, 1, 5, 0);
    check("R6", trig_count, 5);
    // R9: clear wins over a same-cycle trigger
    acc("R9", 8, 2, 1, 0); acc("R9", 8, 1, 2, 0); acc("R9", 8, 3, 3, 1);
    check("R9", trig_count, 0);
    check("R9", irq, 0);
    // R8 and R7: drive triggers on line 9 to threshold and past saturation
    for (int k = 0; k < 130; k++) begin
      acc("R8", 9, 2, k, 0); acc("R8", 9, 3, k + 1, 0); acc("R8", 9, 3, k + 2, 0);
      if (k == 98) begin check("R8", irq, 0); check("R8", trig_count, 99); end
      if (k == 99) begin check("R8", irq, 1); check("R8", trig_count, 100); end
    end
    check("R7", trig_count, 127);
    check("R8", irq, 1);
    // R1: reset mid-run
    do_reset();
    check("R1", trig_count, 0);
    check("R1", irq, 0);
    // R5: every ordered triple of access kinds on every line
    for (int l = 0; l < 64; l++) begin
      acc("R9", l, 4, l, 1);
      for (int s = 0; s < 125; s++) begin
        acc("R5", l, s / 25, s + l, 0);
        acc("R5", l, (s / 5) % 5, s + 2 * l + 1, 0);
        acc("R5", l, s % 5, s + 3 * l + 2, 0);
      end
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule